// File: doc/BRIEF.md
# Usage-Driven Way Ownership Tracker

This block follows replacement ownership for the ways of one cache set that several processors share. Each way may have an owning processor and a small saturating usage counter. A hit on a way raises that way's counter. A miss by some processor lowers the counters of every way that a different processor owns. When one of those counters drops to zero, the owner is treated as not using the way. Ownership then passes straight to the processor whose miss caused the zero, and a one-cycle pulse marks that way.

The cache controller presents one access per cycle. The access carries a valid flag, a hit flag, a way number and the requesting processor number. On a hit, the way number names the way that hit. On a miss, it names the way where the missing block is being installed. If that way has no owner, the requester takes ownership of it. Victim choice, tag lookup and data movement are handled elsewhere. The controller reads the owner fields from this block to decide which ways a processor may evict.

Top module: `own_xfer_tracker`

## Requirements
- R1: After reset, no way has an owner and `xfer_mask` is zero.
- R2: A valid miss whose `acc_way` names an unowned way makes `acc_pid` that way's owner, and its counter loads to half of the maximum count (4 for 3-bit counters). A miss whose `acc_way` names an owned way does not change that way's owner.
- R3: A valid hit on an owned way increments that way's counter by one, whichever processor hits.
- R4: A counter at its maximum (all ones) stays there on further hits.
- R5: A valid miss by processor p decrements the counter of every way owned by a processor other than p. Ways owned by p keep their counters.
- R6: When a decrement takes a counter to zero, that way's owner becomes the missing processor. Bit w of `xfer_mask` is high for exactly the one cycle in which the new owner first appears on `own_id`.
- R7: When several counters reach zero on the same miss, all of those ways change owner in the same cycle, and each of them has its bit set in `xfer_mask`.
- R8: After a transfer, the way's counter reloads to half of the maximum count.
- R9: Ways with no owner are never incremented or decremented. A hit on an unowned way leaves it unowned.
- R10: While `acc_valid` is low, no owner field and no counter changes.
- R11: Owner fields and `xfer_mask` are registered. They reflect an access in the cycle after the clock edge that samples it. The owner of way w is `own_id[w*PID_W +: PID_W]`, valid when `own_valid[w]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to this set is present |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | WAY_W | Way that hit, or the install way on a miss |
| acc_pid | input | PID_W | Requesting processor number |
| own_valid | output | WAYS | Per-way owner-present flag |
| own_id | output | WAYS*PID_W | Packed owner numbers, way 0 in the low bits |
| xfer_mask | output | WAYS | One-cycle pulse per way whose ownership changed hands |

## Verification
The counters are not visible at the ports, so a wrong counter value shows up as a transfer that comes early or late. The error appears as a difference in the number of foreign misses before `xfer_mask` fires, or before `own_id` changes. An extra or missing increment moves that transfer by exactly one miss. A failure to saturate shows up as an early transfer after a run of hits. A wrong reload value shows up the next time the way is taken back. An owner-field error appears one cycle after the access that caused it.

// File: rtl/own_xfer_pkg.sv
package own_xfer_pkg;

    typedef enum logic [2:0] {
        EV_HOLD = 3'd0,
        EV_GAIN = 3'd1,
        EV_UP   = 3'd2,
        EV_WEAR = 3'd3,
        EV_TAKE = 3'd4
    } way_ev_e;

    function automatic int half_count(input int ctr_w);
        return 1 << (ctr_w - 1);
    endfunction

endpackage

// File: rtl/way_event_decode.sv
module way_event_decode
    import own_xfer_pkg::*;
#(
    parameter int PID_W = 2,
    parameter int CTR_W = 3
) (
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic             sel,
    input  logic [PID_W-1:0] acc_pid,
    input  logic             own_valid,
    input  logic [PID_W-1:0] own_id,
    input  logic [CTR_W-1:0] ctr,
    output way_ev_e          ev
);

    always_comb begin
        ev = EV_HOLD;
        if (acc_valid) begin
            if (acc_hit) begin
                if (sel && own_valid) ev = EV_UP;
            end else if (own_valid) begin
                if (own_id != acc_pid)
                    ev = (ctr == CTR_W'(1)) ? EV_TAKE : EV_WEAR;
            end else if (sel) begin
                ev = EV_GAIN;
            end
        end
    end

endmodule

// File: rtl/way_state.sv
module way_state
    import own_xfer_pkg::*;
#(
    parameter int PID_W = 2,
    parameter int CTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  way_ev_e          ev,
    input  logic [PID_W-1:0] acc_pid,
    output logic             own_valid,
    output logic [PID_W-1:0] own_id,
    output logic [CTR_W-1:0] ctr,
    output logic             xfer
);

    localparam logic [CTR_W-1:0] HALF = CTR_W'(half_count(CTR_W));
    localparam logic [CTR_W-1:0] MAXC = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_valid <= 1'b0;
            own_id    <= '0;
            ctr       <= '0;
            xfer      <= 1'b0;
        end else begin
            xfer <= 1'b0;
            unique case (ev)
                EV_GAIN: begin
                    own_valid <= 1'b1;
                    own_id    <= acc_pid;
                    ctr       <= HALF;
                end
                EV_UP:   if (ctr != MAXC) ctr <= ctr + 1'b1;
                EV_WEAR: ctr <= ctr - 1'b1;
                EV_TAKE: begin
                    own_id <= acc_pid;
                    ctr    <= HALF;
                    xfer   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: a claim installs the requester with a half-full counter
    a_r2_claim: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_GAIN) |=> (own_valid && own_id == $past(acc_pid) && ctr == HALF));

    // R4: a saturated counter holds on a hit
    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_UP && ctr == MAXC) |=> (ctr == MAXC));

    // R6: a transfer pulse shows the missing processor as the new owner
    a_r6_new_owner: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (own_valid && own_id == $past(acc_pid) && ctr == HALF));

    // R9: an unowned way keeps an idle counter
    a_r9_unowned_idle: assert property (@(posedge clk) disable iff (rst)
        !own_valid |-> (ctr == '0 && !xfer));

    // R10: no event, no state change
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_HOLD) |=> ($stable(own_id) && $stable(ctr) && $stable(own_valid)));

endmodule

// File: rtl/own_xfer_tracker.sv
module own_xfer_tracker
    import own_xfer_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int PROCS = 4,
    parameter int CTR_W = 3,
    localparam int WAY_W = (WAYS  > 1) ? $clog2(WAYS)  : 1,
    localparam int PID_W = (PROCS > 1) ? $clog2(PROCS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic                  acc_hit,
    input  logic [WAY_W-1:0]      acc_way,
    input  logic [PID_W-1:0]      acc_pid,
    output logic [WAYS-1:0]       own_valid,
    output logic [WAYS*PID_W-1:0] own_id,
    output logic [WAYS-1:0]       xfer_mask
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        way_ev_e          ev;
        logic [CTR_W-1:0] ctr;
        logic [PID_W-1:0] id;

        way_event_decode #(.PID_W(PID_W), .CTR_W(CTR_W)) u_dec (
            .acc_valid (acc_valid),
            .acc_hit   (acc_hit),
            .sel       (acc_way == WAY_W'(w)),
            .acc_pid   (acc_pid),
            .own_valid (own_valid[w]),
            .own_id    (id),
            .ctr       (ctr),
            .ev        (ev)
        );

        way_state #(.PID_W(PID_W), .CTR_W(CTR_W)) u_st (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev),
            .acc_pid   (acc_pid),
            .own_valid (own_valid[w]),
            .own_id    (id),
            .ctr       (ctr),
            .xfer      (xfer_mask[w])
        );

        assign own_id[w*PID_W +: PID_W] = id;
    end

    // R7: every way taken in one cycle goes to the same processor
    for (genvar w = 1; w < WAYS; w++) begin : g_chk
        a_r7_common_taker: assert property (@(posedge clk) disable iff (rst)
            (xfer_mask[w] && xfer_mask[0]) |->
                (own_id[w*PID_W +: PID_W] == own_id[PID_W-1:0]));
    end

    // R1: ownership pulses never precede an owner
    a_r1_pulse_needs_owner: assert property (@(posedge clk) disable iff (rst)
        ((xfer_mask & ~own_valid) == '0));

endmodule

// File: tb/tb_own_xfer_tracker.sv
module tb_own_xfer_tracker;

    localparam int WAYS = 4, PROCS = 4, CTR_W = 3;
    localparam int NV = 35;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0, acc_hit = 1'b0;
    logic [1:0] acc_way = '0, acc_pid = '0;
    logic [3:0] own_valid;
    logic [7:0] own_id;
    logic [3:0] xfer_mask;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    own_xfer_tracker #(.WAYS(WAYS), .PROCS(PROCS), .CTR_W(CTR_W)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .acc_pid(acc_pid), .own_valid(own_valid),
        .own_id(own_id), .xfer_mask(xfer_mask)
    );

    // {valid, hit, way[1:0], pid[1:0], exp_valid[3:0], exp_ids{w3,w2,w1,w0}[7:0], exp_xfer[3:0]}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1,1'b0,2'd0,2'd0, 4'b0001, 8'b00_00_00_00, 4'b0000}, // 0  R2 claim w0
        {1'b1,1'b0,2'd1,2'd1, 4'b0011, 8'b00_00_01_00, 4'b0000}, // 1  R2/R5
        {1'b1,1'b0,2'd2,2'd2, 4'b0111, 8'b00_10_01_00, 4'b0000}, // 2
        {1'b1,1'b1,2'd0,2'd3, 4'b0111, 8'b00_10_01_00, 4'b0000}, // 3  R3 foreign hit
        {1'b1,1'b1,2'd3,2'd0, 4'b0111, 8'b00_10_01_00, 4'b0000}, // 4  R9 hit unowned
        {1'b0,1'b0,2'd3,2'd3, 4'b0111, 8'b00_10_01_00, 4'b0000}, // 5  R10 idle
        {1'b1,1'b0,2'd1,2'd0, 4'b0111, 8'b00_10_01_00, 4'b0000}, // 6  R2 owned way not claimed
        {1'b1,1'b0,2'd1,2'd0, 4'b0111, 8'b00_10_01_00, 4'b0000}, // 7
        {1'b1,1'b0,2'd1,2'd0, 4'b0111, 8'b00_10_00_00, 4'b0010}, // 8  R6 w1 -> P0
        {1'b1,1'b0,2'd1,2'd3, 4'b0111, 8'b00_11_00_00, 4'b0100}, // 9  R6 w2 -> P3
        {1'b1,1'b1,2'd1,2'd0, 4'b0111, 8'b00_11_00_00, 4'b0000}, // 10 R6 pulse gone
        {1'b1,1'b1,2'd0,2'd0, 4'b0111, 8'b00_11_00_00, 4'b0000}, // 11
        {1'b1,1'b1,2'd0,2'd0, 4'b0111, 8'b00_11_00_00, 4'b0000}, // 12
        {1'b1,1'b0,2'd0,2'd1, 4'b0111, 8'b00_11_00_00, 4'b0000}, // 13 R5
        {1'b1,1'b0,2'd0,2'd1, 4'b0111, 8'b00_11_00_00, 4'b0000}, // 14
        {1'b1,1'b0,2'd0,2'd1, 4'b0111, 8'b00_11_00_00, 4'b0000}, // 15
        {1'b1,1'b0,2'd0,2'd1, 4'b0111, 8'b00_01_01_01, 4'b0111}, // 16 R7 triple
        {1'b1,1'b0,2'd3,2'd1, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 17 R2 claim w3
        {1'b1,1'b1,2'd3,2'd0, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 18 R4 hits
        {1'b1,1'b1,2'd3,2'd0, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 19
        {1'b1,1'b1,2'd3,2'd0, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 20
        {1'b1,1'b1,2'd3,2'd0, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 21
        {1'b1,1'b1,2'd3,2'd0, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 22
        {1'b1,1'b1,2'd3,2'd0, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 23
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 24
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 25
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b01_01_01_01, 4'b0000}, // 26
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b01_10_10_10, 4'b0111}, // 27 R8 reload check
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b01_10_10_10, 4'b0000}, // 28 R4
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b01_10_10_10, 4'b0000}, // 29
        {1'b1,1'b0,2'd0,2'd2, 4'b1111, 8'b10_10_10_10, 4'b1000}, // 30 R4 saturated at 7
        {1'b1,1'b0,2'd0,2'd0, 4'b1111, 8'b10_10_10_10, 4'b0000}, // 31 R8
        {1'b1,1'b0,2'd0,2'd0, 4'b1111, 8'b10_10_10_10, 4'b0000}, // 32
        {1'b1,1'b0,2'd0,2'd0, 4'b1111, 8'b10_10_10_10, 4'b0000}, // 33
        {1'b1,1'b0,2'd0,2'd0, 4'b1111, 8'b00_00_00_00, 4'b1111}  // 34 R8/R7
    };

    function automatic string tag_of(input int i);
        if (i <= 2)        return "R2";
        else if (i == 3)   return "R3";
        else if (i == 4)   return "R9";
        else if (i == 5)   return "R10";
        else if (i <= 7)   return "R5";
        else if (i <= 10)  return "R6";
        else if (i <= 15)  return "R5";
        else if (i == 16)  return "R7";
        else if (i == 17)  return "R2";
        else if (i <= 26)  return "R4";
        else if (i == 27)  return "R8";
        else if (i <= 30)  return "R4";
        else               return "R8";
    endfunction

    task automatic check(input string tag, input logic [3:0] ev, input logic [7:0] ei,
                         input logic [3:0] ex);
        checks++;
        if (own_valid !== ev || own_id !== ei || xfer_mask !== ex) begin
            errors++;
            $display("FAIL %s: valid=%b id=%b xfer=%b expected valid=%b id=%b xfer=%b",
                     tag, own_valid, own_id, xfer_mask, ev, ei, ex);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 4'b0000, 8'h00, 4'b0000);   // R1 reset state, R11 layout
        for (int i = 0; i < NV; i++) begin
            {acc_valid, acc_hit, acc_way, acc_pid} = VEC[i][21:16];
            @(posedge clk);
            @(negedge clk);
            check(tag_of(i), VEC[i][15:12], VEC[i][11:4], VEC[i][3:0]); // R11 one cycle
        end
        // R10: long idle with a miss pattern on the pins changes nothing
        acc_valid = 1'b0; acc_hit = 1'b0; acc_pid = 2'd3;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check("R10", 4'b1111, 8'h00, 4'b0000);
        // R1: reset mid-run clears all ownership
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 4'b0000, 8'h00, 4'b0000);
        // R9: misses with nothing owned and a hit on an unowned way
        acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 2'd2; acc_pid = 2'd1;
        @(posedge clk);
        @(negedge clk);
        check("R9", 4'b0000, 8'h00, 4'b0000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule